// File: doc/BRIEF.md
# Selectable-Order Sinc Decimator

This block turns a one-bit sigma-delta bitstream into multi-bit samples. A cascade of wrapping integrators accumulates the stream one bit at a time. At the end of each decimation window, a matching cascade of difference stages converts the integrator value into a sample. The filter order is chosen at run time: two or three stages. Every accumulator is 27 bits wide and wraps modulo 2^27. Because of this, the window length has a ceiling for each order: 512 bits for order three and 11585 bits for order two.

Each sample is the average bit density over the whole window. There is no sample-and-hold, so the output trails the input. The 27-bit difference is placed into a 32-bit output word in one of two ways. The default zero-fills the five top bits. The alternative shifts the value left by five. Either way, stale upper bits from the wrapping arithmetic never reach the output.

Software writes a new window length into a pending register. The value takes effect at the next window boundary, or at once when the order changes. A change of order restarts the filter from a cleared state.

Top module: `sinc_decim`

## Requirements
- R1: All integrator and difference arithmetic wraps modulo 2^27. With order three, a 512-bit window and an all-ones stream, the settled sample is exactly 0.
- R2: A window holds exactly P accepted bits, where P is the active period. For a stream with a repeating 8-bit pattern and P a multiple of 8, the settled sample equals (ones in the window) * P^(order-1), mod 2^27.
- R3: A cycle with `bit_en` low has no effect on the filter, whatever `bit_in` holds.
- R4: `sample_vld` is high for exactly one clock. That clock is the one right after the edge that takes the last bit of a window.
- R5: A `period_wr` pulse only loads a pending value. The window in progress keeps its length, and the new length applies from the next window.
- R6: A period above the limit for the current order is clamped to that limit: 512 for order 3 and 11585 for order 2. A period below 2 is raised to 2. `period_clamped` is 1 while the active period came from clamping, and 0 otherwise.
- R7: With `scale_mode` = 0, the sample is the 27-bit result zero-extended, so bits 31..27 are 0.
- R8: With `scale_mode` = 1, the sample is the 27-bit result shifted left by 5, so bits 4..0 are 0.
- R9: `order_sel` = 1 selects order 3 and 0 selects order 2. Changing `order_sel` clears all filter state and the window counter, and loads the pending period. The first N samples after a reset or an order change carry `sample_settling` = 1, where N is the order. Later samples carry 0.
- R10: Synchronous `rst` clears integrators, difference delays and the window counter. It also drives `sample_out`, `sample_vld`, `sample_settling` and `period_clamped` to 0, and sets the active and pending period to 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Accept `bit_in` this cycle |
| bit_in | input | 1 | Modulator bitstream bit |
| order_sel | input | 1 | 1 = third order, 0 = second order |
| scale_mode | input | 1 | 0 = zero-fill top bits, 1 = shift left by 5 |
| period_wr | input | 1 | Load `period_in` into the pending period |
| period_in | input | 14 | Requested window length in bits |
| sample_out | output | 32 | Decimated sample |
| sample_vld | output | 1 | One-clock strobe for `sample_out` |
| sample_settling | output | 1 | Sample taken before the difference stages filled |
| period_clamped | output | 1 | Active period was limited by clamping |

## Verification
The hardest condition to reach from the ports is the modular wrap. An order-three window of 512 all-ones bits produces a true result of exactly 2^27, which must come out as 0. The bench reaches it by writing the maximum period and then toggling the order to force a restart that loads the period immediately. The next hardest is a period write that lands in the middle of a window. The bench places it a set number of accepted bits into the second window. It then timestamps every strobe against its own count of accepted bits, which shows both the unchanged window and the new one.

// File: rtl/sinc_pkg.sv
package sinc_pkg;

  localparam int ACC_W   = 27;
  localparam int OUT_W   = 32;
  localparam int PER_W   = 14;
  localparam int STAGES  = 3;
  localparam int MIN_PER = 2;

  // Largest r with r**k <= v, evaluated at elaboration time.
  function automatic int unsigned int_root(input longint unsigned v, input int k);
    int unsigned r;
    r = 0;
    for (int b = 15; b >= 0; b--) begin
      longint unsigned t;
      longint unsigned p;
      t = longint'(r) | (longint'(1) << b);
      p = 1;
      for (int j = 0; j < k; j++) p = p * t;
      if (p <= v) r = int'(t);
    end
    return r;
  endfunction

  localparam int LIM3 = int'(int_root(longint'(1) << ACC_W, 3));
  localparam int LIM2 = int'(int_root(longint'(1) << ACC_W, 2));

  function automatic logic [PER_W-1:0] period_limit(input logic ord3);
    return ord3 ? PER_W'(LIM3) : PER_W'(LIM2);
  endfunction

  function automatic logic [PER_W-1:0] clamp_period(input logic [PER_W-1:0] raw,
                                                    input logic ord3);
    logic [PER_W-1:0] lim;
    lim = period_limit(ord3);
    if (raw < PER_W'(MIN_PER)) return PER_W'(MIN_PER);
    if (raw > lim) return lim;
    return raw;
  endfunction

  function automatic logic [OUT_W-1:0] format_out(input logic [ACC_W-1:0] d,
                                                  input logic shift);
    if (shift) return {d, {(OUT_W-ACC_W){1'b0}}};
    return {{(OUT_W-ACC_W){1'b0}}, d};
  endfunction

endpackage

// File: rtl/sinc_integ_chain.sv
module sinc_integ_chain #(
  parameter int ACC_W  = sinc_pkg::ACC_W,
  parameter int STAGES = sinc_pkg::STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  input  logic             ord3,
  output logic [ACC_W-1:0] tap
);
  logic [ACC_W-1:0] acc_q   [STAGES];
  logic [ACC_W-1:0] acc_nxt [STAGES];

  // Each stage adds the freshly updated value of the stage before it.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign acc_nxt[s] = acc_q[s] + ACC_W'(din);
    end else begin : g_rest
      assign acc_nxt[s] = acc_q[s] + acc_nxt[s-1];
    end

    always_ff @(posedge clk) begin
      if (rst || clr) acc_q[s] <= '0;
      else if (en)    acc_q[s] <= acc_nxt[s];
    end
  end

  assign tap = ord3 ? acc_nxt[STAGES-1] : acc_nxt[STAGES-2];
endmodule

// File: rtl/sinc_comb_chain.sv
module sinc_comb_chain #(
  parameter int ACC_W  = sinc_pkg::ACC_W,
  parameter int STAGES = sinc_pkg::STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic             ord3,
  input  logic [ACC_W-1:0] tap_in,
  output logic [ACC_W-1:0] diff
);
  logic [ACC_W-1:0] dly_q [STAGES];
  logic [ACC_W-1:0] dif   [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign dif[s] = tap_in - dly_q[s];
      always_ff @(posedge clk) begin
        if (rst || clr) dly_q[s] <= '0;
        else if (load)  dly_q[s] <= tap_in;
      end
    end else begin : g_rest
      assign dif[s] = dif[s-1] - dly_q[s];
      always_ff @(posedge clk) begin
        if (rst || clr) dly_q[s] <= '0;
        else if (load)  dly_q[s] <= dif[s-1];
      end
    end
  end

  assign diff = ord3 ? dif[STAGES-1] : dif[STAGES-2];
endmodule

// File: rtl/sinc_window_ctrl.sv
module sinc_window_ctrl #(
  parameter int PER_W      = sinc_pkg::PER_W,
  parameter int DEF_PERIOD = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             en,
  input  logic             ord3,
  input  logic             per_wr,
  input  logic [PER_W-1:0] per_in,
  output logic             boundary,
  output logic             settling_now,
  output logic             clamped,
  output logic [PER_W-1:0] active_period
);
  import sinc_pkg::*;

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] pend_q;
  logic [1:0]       settle_q;
  logic [PER_W-1:0] next_per;
  logic [1:0]       fill_windows;

  assign next_per     = clamp_period(pend_q, ord3);
  assign fill_windows = ord3 ? 2'd3 : 2'd2;
  assign boundary     = en && !restart && (cnt_q == active_period - PER_W'(1));
  assign settling_now = (settle_q != 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q         <= '0;
      pend_q        <= PER_W'(DEF_PERIOD);
      active_period <= PER_W'(DEF_PERIOD);
      clamped       <= 1'b0;
      settle_q      <= fill_windows;
    end else begin
      if (per_wr) pend_q <= per_in;
      if (restart) begin
        cnt_q         <= '0;
        active_period <= next_per;
        clamped       <= (next_per != pend_q);
        settle_q      <= fill_windows;
      end else if (en) begin
        if (boundary) begin
          cnt_q         <= '0;
          active_period <= next_per;
          clamped       <= (next_per != pend_q);
          if (settling_now) settle_q <= settle_q - 2'd1;
        end else begin
          cnt_q <= cnt_q + PER_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sinc_decim.sv
module sinc_decim #(
  parameter int ACC_W      = sinc_pkg::ACC_W,
  parameter int OUT_W      = sinc_pkg::OUT_W,
  parameter int PER_W      = sinc_pkg::PER_W,
  parameter int STAGES     = sinc_pkg::STAGES,
  parameter int DEF_PERIOD = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             order_sel,
  input  logic             scale_mode,
  input  logic             period_wr,
  input  logic [PER_W-1:0] period_in,
  output logic [OUT_W-1:0] sample_out,
  output logic             sample_vld,
  output logic             sample_settling,
  output logic             period_clamped
);
  import sinc_pkg::*;

  logic             order_q;
  logic             order_change;
  logic             acc_en;
  logic             boundary;
  logic             settling_now;
  logic [PER_W-1:0] active_period;
  logic [ACC_W-1:0] integ_tap;
  logic [ACC_W-1:0] comb_diff;

  assign order_change = (order_sel != order_q);
  assign acc_en       = bit_en && !order_change;

  always_ff @(posedge clk) begin
    if (rst) order_q <= order_sel;
    else     order_q <= order_sel;
  end

  sinc_window_ctrl #(.PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD)) u_win (
    .clk          (clk),
    .rst          (rst),
    .restart      (order_change),
    .en           (bit_en),
    .ord3         (order_sel),
    .per_wr       (period_wr),
    .per_in       (period_in),
    .boundary     (boundary),
    .settling_now (settling_now),
    .clamped      (period_clamped),
    .active_period(active_period)
  );

  sinc_integ_chain #(.ACC_W(ACC_W), .STAGES(STAGES)) u_integ (
    .clk (clk),
    .rst (rst),
    .clr (order_change),
    .en  (acc_en),
    .din (bit_in),
    .ord3(order_q),
    .tap (integ_tap)
  );

  sinc_comb_chain #(.ACC_W(ACC_W), .STAGES(STAGES)) u_comb (
    .clk   (clk),
    .rst   (rst),
    .clr   (order_change),
    .load  (boundary),
    .ord3  (order_q),
    .tap_in(integ_tap),
    .diff  (comb_diff)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_out      <= '0;
      sample_vld      <= 1'b0;
      sample_settling <= 1'b0;
    end else begin
      sample_vld <= boundary;
      if (boundary) begin
        sample_out      <= format_out(comb_diff, scale_mode);
        sample_settling <= settling_now;
      end
    end
  end
endmodule

// File: rtl/sinc_decim_chk.sv
module sinc_decim_chk #(
  parameter int OUT_W = sinc_pkg::OUT_W,
  parameter int PER_W = sinc_pkg::PER_W
) (
  input logic             clk,
  input logic             rst,
  input logic             sample_vld,
  input logic [OUT_W-1:0] sample_out,
  input logic             scale_mode,
  input logic             boundary,
  input logic             order_change,
  input logic             order_q,
  input logic [PER_W-1:0] active_period
);
  import sinc_pkg::*;

  p_vld_single_r4: assert property (@(posedge clk) disable iff (rst)
    sample_vld |=> !sample_vld);

  p_vld_follows_boundary_r4: assert property (@(posedge clk) disable iff (rst)
    sample_vld |-> $past(boundary));

  p_top_bits_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (sample_vld && !$past(scale_mode)) |-> (sample_out[OUT_W-1:OUT_W-5] == 5'd0));

  p_low_bits_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (sample_vld && $past(scale_mode)) |-> (sample_out[4:0] == 5'd0));

  p_period_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    !order_change |-> (active_period <= period_limit(order_q) &&
                       active_period >= PER_W'(MIN_PER)));

  p_restart_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    order_change |=> !sample_vld);
endmodule

bind sinc_decim sinc_decim_chk #(.OUT_W(OUT_W), .PER_W(PER_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sample_vld   (sample_vld),
  .sample_out   (sample_out),
  .scale_mode   (scale_mode),
  .boundary     (boundary),
  .order_change (order_change),
  .order_q      (order_q),
  .active_period(active_period)
);

// File: tb/sinc_decim_tb.sv
module sinc_decim_tb;
  logic        clk = 1'b0;
  logic        rst, bit_en, bit_in, order_sel, scale_mode, period_wr;
  logic [13:0] period_in;
  logic [31:0] sample_out;
  logic        sample_vld, sample_settling, period_clamped;
  logic        tb_clr;
  int          en_cnt;
  int          n_chk = 0, n_fail = 0;
  int          cap_n = 0, dbl_vld = 0;
  logic        prev_vld = 1'b0;
  logic [31:0] cap_val [8];
  logic        cap_set [8];
  int          cap_bits[8];
  bit          done = 0;

  always #4 clk = ~clk;

  sinc_decim u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .order_sel(order_sel), .scale_mode(scale_mode), .period_wr(period_wr),
    .period_in(period_in), .sample_out(sample_out), .sample_vld(sample_vld),
    .sample_settling(sample_settling), .period_clamped(period_clamped)
  );

  // Vector table: order, period, ones per 8 bits, scale, gapped enable, raw result
  localparam int V_N = 8;
  localparam int V_ORD [V_N] = '{3, 2, 3, 3, 2, 3, 2, 3};
  localparam int V_PER [V_N] = '{64, 64, 512, 512, 1000, 200, 11584, 96};
  localparam int V_ONE [V_N] = '{4, 8, 8, 5, 3, 1, 7, 0};
  localparam int V_SC  [V_N] = '{0, 0, 0, 0, 1, 0, 0, 0};
  localparam int V_GAP [V_N] = '{0, 0, 0, 1, 0, 1, 0, 0};
  localparam int V_EXP [V_N] = '{131072, 4096, 0, 83886080, 375000, 1000000,
                                  117415424, 0};

  always @(posedge clk) begin
    if (tb_clr) en_cnt <= 0;
    else if (bit_en) en_cnt <= en_cnt + 1;
  end

  always @(negedge clk) begin
    if (sample_vld && prev_vld) dbl_vld++;
    prev_vld = sample_vld;
    if (sample_vld && cap_n < 8) begin
      cap_val[cap_n]  = sample_out;
      cap_set[cap_n]  = sample_settling;
      cap_bits[cap_n] = en_cnt;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart_with(input int ord, input int per, input int sc);
    @(negedge clk); bit_en = 0; scale_mode = sc[0]; order_sel = (ord != 3);
    @(negedge clk); period_wr = 1; period_in = 14'(per);
    @(negedge clk); period_wr = 0; order_sel = (ord == 3); tb_clr = 1; cap_n = 0;
    @(negedge clk); tb_clr = 0;
  endtask

  task automatic drive_bits(input int cnt, input int ones8, input int gap,
                            input int wr_at, input int wr_val);
    for (int b = 0; b < cnt; b++) begin
      bit_en = 1; bit_in = ((b % 8) < ones8);
      period_wr = (b == wr_at); period_in = 14'(wr_val);
      @(negedge clk);
      period_wr = 0;
      if (gap != 0) begin
        bit_en = 0; bit_in = ~bit_in;   // R3: ignored while disabled
        repeat (2) @(negedge clk);
      end
    end
    bit_en = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; bit_en = 0; bit_in = 0; order_sel = 1; scale_mode = 0;
    period_wr = 0; period_in = 0; tb_clr = 1;
    repeat (2) @(negedge clk);
    bit_en = 1; bit_in = 1;
    repeat (2) @(negedge clk);
    bit_en = 0; rst = 0; tb_clr = 0;
    @(negedge clk);
    // R10: reset state
    chk(sample_out == 0 && !sample_vld, "R10 out/vld", sample_out, 0);
    chk(!sample_settling && !period_clamped, "R10 flags",
        {sample_settling, period_clamped}, 0);

    // Table walk
    for (int i = 0; i < V_N; i++) begin
      int k;
      logic [31:0] e32;
      k   = V_ORD[i];
      e32 = (V_SC[i] != 0) ? (32'(V_EXP[i]) << 5) : 32'(V_EXP[i]);
      restart_with(V_ORD[i], V_PER[i], V_SC[i]);
      drive_bits((k + 2) * V_PER[i], V_ONE[i], V_GAP[i], -1, 0);
      chk(cap_n == k + 2, "R2 window count", cap_n, k + 2);
      for (int w = 0; w < k + 2; w++) begin
        chk(cap_bits[w] == V_PER[i] * (w + 1), "R2 window length",
            cap_bits[w], V_PER[i] * (w + 1));
        chk(cap_set[w] == (w < k), "R9 settling flag", cap_set[w], w < k);
        if (w >= k) begin
          chk(cap_val[w] == e32, (V_GAP[i] != 0) ? "R3 gapped value" : "R2 value",
              cap_val[w], e32);
          if (i == 2) chk(cap_val[w] == 0, "R1 wrap to zero", cap_val[w], 0);
          if (V_SC[i] != 0) chk(cap_val[w][4:0] == 0, "R8 shift", cap_val[w][4:0], 0);
          else chk(cap_val[w][31:27] == 0, "R7 top bits", cap_val[w][31:27], 0);
        end
      end
    end
    chk(dbl_vld == 0, "R4 single strobe", dbl_vld, 0);

    // R5: period write mid-window
    restart_with(3, 64, 0);
    drive_bits(384, 8, 0, 84, 128);
    chk(cap_bits[1] == 128, "R5 current window kept", cap_bits[1], 128);
    chk(cap_bits[2] == 256, "R5 new period applied", cap_bits[2], 256);
    chk(cap_bits[3] == 384, "R5 new period repeats", cap_bits[3], 384);

    // R6: clamping
    restart_with(3, 1000, 0);
    chk(period_clamped == 1, "R6 flag order3", period_clamped, 1);
    drive_bits(600, 8, 0, -1, 0);
    chk(cap_bits[0] == 512, "R6 order3 limit", cap_bits[0], 512);
    restart_with(2, 12000, 0);
    chk(period_clamped == 1, "R6 flag order2", period_clamped, 1);
    drive_bits(11600, 8, 0, -1, 0);
    chk(cap_bits[0] == 11585, "R6 order2 limit", cap_bits[0], 11585);
    restart_with(2, 11585, 0);
    chk(period_clamped == 0, "R6 at limit no flag", period_clamped, 0);
    restart_with(3, 1, 0);
    chk(period_clamped == 1, "R6 low flag", period_clamped, 1);
    drive_bits(5, 8, 0, -1, 0);
    chk(cap_bits[0] == 2 && cap_bits[1] == 4, "R6 minimum period", cap_bits[1], 4);
    restart_with(3, 300, 0);
    chk(period_clamped == 0, "R6 in range", period_clamped, 0);

    // R10: reset mid-run clears filter state
    restart_with(3, 64, 0);
    drive_bits(100, 8, 0, -1, 0);
    @(negedge clk); rst = 1; tb_clr = 1;
    @(negedge clk); rst = 0; tb_clr = 0; cap_n = 0;
    drive_bits(320, 8, 0, -1, 0);
    chk(cap_n == 5, "R10 windows after reset", cap_n, 5);
    chk(cap_set[2] == 1 && cap_set[3] == 0, "R10 settle restarted", cap_set[3], 0);
    chk(cap_val[3] == 262144, "R10 cleared state", cap_val[3], 262144);
    chk(cap_bits[0] == 64, "R10 default period", cap_bits[0], 64);
    chk(dbl_vld == 0, "R4 single strobe end", dbl_vld, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule